// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritizer

This block gathers every interrupt cause of a FIFO-based UART and reduces them to one interrupt request line and a 32-bit read-only identification word. Six prioritized causes share a 3-bit code field and an active-low "nothing pending" bit: receive line errors, receive data at or above the trigger level, receive character time-out, holding register empty, transmitter empty, and modem line changes. Three further causes sit beside the code field as separate sticky bits: auto-baud finished, auto-baud timed out, and transmit error.

The surrounding UART supplies single-cycle event pulses, the receive FIFO fill level and trigger level, a 16x baud tick, the configured character length in bits, a per-source enable mask, and one-cycle strobes that mark accesses to the identification, line-status, receive-buffer, modem-status and transmit-holding registers. The block applies each cause's clear-on-access rule from those strobes. The receive time-out is timed in baud ticks over four character lengths.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held and right after it, with `fifoEn` low, `identWord` equals 0x00000001 and `irq` is 0.
- R2: `identWord[3:1]` holds the code of the cause being reported: line error 3'h3, data available 3'h2, time-out 3'h6, holding empty 3'h1, transmitter empty 3'h7, modem change 3'h0. `identWord[0]` is 0 when a prioritized cause is reported and 1 otherwise, and the code is 3'h0 when nothing is reported.
- R3: The reported cause is chosen in this order: line error, then data available, then time-out, then holding empty, then transmitter empty, then modem change.
- R4: Any bit of `lineErr` (overrun, parity, framing, break) latches a line-error cause that clears on `rdLineStat`. A new error in the same cycle as the read keeps the cause set.
- R5: Data available is reported while `rxLevel` is nonzero and at least `rxTrigger`. It stops as soon as the level falls below the trigger.
- R6: With the FIFO nonempty, the time-out cause rises on the baud tick that completes `frameBits`*64 ticks without any `rxPush` or `rdRxBuf`. Either strobe restarts the count and clears the cause.
- R7: Holding-empty and transmitter-empty causes clear on `wrThr`. `rdIdent` clears only the one currently reported and leaves the other.
- R8: Any bit of `modemChg` latches a modem-change cause that clears on `rdModem`.
- R9: `identWord[8]` (auto-baud done) and `identWord[9]` (auto-baud time-out) set on their event only when enable bit 5 or 6 is 1. They stay set through `rdIdent` and clear only on `abEndClr` or `abToClr`.
- R10: `identWord[10]` sets on `txErrEvt` only when enable bit 7 is 1, and clears on `txErrClr`.
- R11: `identWord[7:6]` both follow `fifoEn`. Bits 5:4 and 31:11 read 0.
- R12: `ienMask` bits enable causes as follows: bit 0 line error, bit 1 data available and time-out, bit 2 holding empty, bit 3 transmitter empty, bit 4 modem change, bits 5, 6 and 7 the three sticky bits. A latched cause that is disabled is not reported. `irq` is 1 exactly when a prioritized cause is reported or an enabled sticky bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | FIFO enable state, mirrored into bits 7:6 |
| ienMask | input | 8 | Per-cause enable mask |
| lineErr | input | 4 | Error pulses: overrun, parity, framing, break |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| rxTrigger | input | LVL_W | Receive trigger level |
| rxPush | input | 1 | A character entered the receive FIFO |
| baudTick | input | 1 | 16x baud tick |
| frameBits | input | FRAME_W | Bits per character frame |
| thrEmptyEvt | input | 1 | Holding register became empty |
| txEmptyEvt | input | 1 | Transmitter became fully empty |
| modemChg | input | 4 | Change pulses: CTS, DSR, RI, DCD |
| abEndEvt | input | 1 | Auto-baud finished |
| abToEvt | input | 1 | Auto-baud timed out |
| txErrEvt | input | 1 | Transmit error event |
| abEndClr | input | 1 | Clears the auto-baud done bit |
| abToClr | input | 1 | Clears the auto-baud time-out bit |
| txErrClr | input | 1 | Clears the transmit error bit |
| rdIdent | input | 1 | Identification register read |
| rdLineStat | input | 1 | Line status register read |
| rdRxBuf | input | 1 | Receive buffer read (FIFO pop) |
| rdModem | input | 1 | Modem status register read |
| wrThr | input | 1 | Transmit holding register write |
| identWord | output | 32 | Identification word |
| irq | output | 1 | Interrupt request |

## Verification
A table of cycles stacks causes on top of each other so that each read or write has to remove exactly the right one. One example is holding-empty and transmitter-empty pending together, cleared by two identification reads. Others are a line error arriving in the same cycle as its clearing read, and causes latched while disabled and then revealed by the enable mask. The level-driven data-available cause is tested at, below and above the trigger. This shows that it follows the level and is never latched. Directed runs hold the FIFO nonempty under a continuous baud tick and sample one cycle before and on the tick where the time-out should rise, both from a fresh start and after a push midway. The sticky auto-baud and transmit-error bits are driven with their enable off and on, then read and explicitly cleared.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    CODE_MODEM = 3'h0,
    CODE_THRE  = 3'h1,
    CODE_RDA   = 3'h2,
    CODE_LINE  = 3'h3,
    CODE_CTO   = 3'h6,
    CODE_TEMT  = 3'h7
  } irq_code_e;

  // enable mask bit positions
  localparam int EN_LINE  = 0;
  localparam int EN_RX    = 1;
  localparam int EN_THRE  = 2;
  localparam int EN_TEMT  = 3;
  localparam int EN_MODEM = 4;
  localparam int EN_ABEND = 5;
  localparam int EN_ABTO  = 6;
  localparam int EN_TXERR = 7;
  localparam int EN_W     = 8;

  // latched cause flags
  localparam int F_LINE  = 0;
  localparam int F_MODEM = 1;
  localparam int F_THRE  = 2;
  localparam int F_TEMT  = 3;
  localparam int F_ABEND = 4;
  localparam int F_ABTO  = 5;
  localparam int F_TXERR = 6;
  localparam int N_FLAG  = 7;

  typedef struct packed {
    logic clrLine;
    logic clrModem;
    logic clrThre;
    logic clrTemt;
    logic clrAbEnd;
    logic clrAbTo;
    logic clrTxErr;
    logic restartCto;
  } irq_strobe_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic        rdIdent,
  input  logic        rdLineStat,
  input  logic        rdRxBuf,
  input  logic        rdModem,
  input  logic        wrThr,
  input  logic        rxPush,
  input  logic        abEndClr,
  input  logic        abToClr,
  input  logic        txErrClr,
  input  irq_code_e   reportCode,
  input  logic        reportValid,
  output irq_strobe_t strobe
);

  logic identTakesThre;
  logic identTakesTemt;

  // an identification read retires only the cause it returned
  assign identTakesThre = rdIdent && reportValid && (reportCode == CODE_THRE);
  assign identTakesTemt = rdIdent && reportValid && (reportCode == CODE_TEMT);

  always_comb begin
    strobe            = '0;
    strobe.clrLine    = rdLineStat;
    strobe.clrModem   = rdModem;
    strobe.clrThre    = wrThr || identTakesThre;
    strobe.clrTemt    = wrThr || identTakesTemt;
    strobe.clrAbEnd   = abEndClr;
    strobe.clrAbTo    = abToClr;
    strobe.clrTxErr   = txErrClr;
    strobe.restartCto = rxPush || rdRxBuf;
  end

endmodule

// File: rtl/uart_irq_cto_timer.sv
module uart_irq_cto_timer #(
  parameter int FRAME_W           = 4,
  parameter int TICKS_PER_BIT     = 16,
  parameter int FRAMES_PER_WINDOW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baudTick,
  input  logic [FRAME_W-1:0] frameBits,
  input  logic               fifoNonEmpty,
  input  logic               restart,
  output logic               expired
);

  localparam int SCALE = TICKS_PER_BIT * FRAMES_PER_WINDOW;
  localparam int CNT_W = FRAME_W + $clog2(SCALE);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] window;
  logic [CNT_W-1:0] windowLast;
  logic             atLast;

  assign window     = CNT_W'(frameBits) * CNT_W'(SCALE);
  assign windowLast = window - CNT_W'(1);
  assign atLast     = (window != '0) && (count == windowLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (restart || !fifoNonEmpty) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (baudTick && !expired) begin
      if (atLast) begin
        expired <= 1'b1;
      end else begin
        count <= count + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int LVL_W             = 5,
  parameter int FRAME_W           = 4,
  parameter int TICKS_PER_BIT     = 16,
  parameter int FRAMES_PER_WINDOW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoEn,
  input  logic [EN_W-1:0]    ienMask,
  input  logic [3:0]         lineErr,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   rxTrigger,
  input  logic               baudTick,
  input  logic [FRAME_W-1:0] frameBits,
  input  logic               thrEmptyEvt,
  input  logic               txEmptyEvt,
  input  logic [3:0]         modemChg,
  input  logic               abEndEvt,
  input  logic               abToEvt,
  input  logic               txErrEvt,
  input  irq_strobe_t        strobe,
  output irq_code_e          reportCode,
  output logic               reportValid,
  output logic [31:0]        identWord,
  output logic               irq
);

  logic [N_FLAG-1:0] flagSet;
  logic [N_FLAG-1:0] flagClr;
  logic [N_FLAG-1:0] flags;
  logic              ctoExpired;
  logic              lineAct;
  logic              rdaAct;
  logic              ctoAct;
  logic              threAct;
  logic              temtAct;
  logic              modemAct;
  logic              stickyAct;

  always_comb begin
    flagSet          = '0;
    flagSet[F_LINE]  = |lineErr;
    flagSet[F_MODEM] = |modemChg;
    flagSet[F_THRE]  = thrEmptyEvt;
    flagSet[F_TEMT]  = txEmptyEvt;
    flagSet[F_ABEND] = abEndEvt && ienMask[EN_ABEND];
    flagSet[F_ABTO]  = abToEvt && ienMask[EN_ABTO];
    flagSet[F_TXERR] = txErrEvt && ienMask[EN_TXERR];

    flagClr          = '0;
    flagClr[F_LINE]  = strobe.clrLine;
    flagClr[F_MODEM] = strobe.clrModem;
    flagClr[F_THRE]  = strobe.clrThre;
    flagClr[F_TEMT]  = strobe.clrTemt;
    flagClr[F_ABEND] = strobe.clrAbEnd;
    flagClr[F_ABTO]  = strobe.clrAbTo;
    flagClr[F_TXERR] = strobe.clrTxErr;
  end

  // one set-dominant latch per cause
  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flags[i] <= 1'b0;
      end else if (flagSet[i]) begin
        flags[i] <= 1'b1;
      end else if (flagClr[i]) begin
        flags[i] <= 1'b0;
      end
    end
  end

  uart_irq_cto_timer #(
    .FRAME_W          (FRAME_W),
    .TICKS_PER_BIT    (TICKS_PER_BIT),
    .FRAMES_PER_WINDOW(FRAMES_PER_WINDOW)
  ) u_ctoTimer (
    .clk         (clk),
    .rstN        (rstN),
    .baudTick    (baudTick),
    .frameBits   (frameBits),
    .fifoNonEmpty(rxLevel != '0),
    .restart     (strobe.restartCto),
    .expired     (ctoExpired)
  );

  assign lineAct  = flags[F_LINE] && ienMask[EN_LINE];
  assign rdaAct   = ienMask[EN_RX] && (rxLevel != '0) && (rxLevel >= rxTrigger);
  assign ctoAct   = ienMask[EN_RX] && ctoExpired;
  assign threAct  = flags[F_THRE] && ienMask[EN_THRE];
  assign temtAct  = flags[F_TEMT] && ienMask[EN_TEMT];
  assign modemAct = flags[F_MODEM] && ienMask[EN_MODEM];

  always_comb begin
    reportValid = 1'b1;
    reportCode  = CODE_MODEM;
    if (lineAct) begin
      reportCode = CODE_LINE;
    end else if (rdaAct) begin
      reportCode = CODE_RDA;
    end else if (ctoAct) begin
      reportCode = CODE_CTO;
    end else if (threAct) begin
      reportCode = CODE_THRE;
    end else if (temtAct) begin
      reportCode = CODE_TEMT;
    end else if (modemAct) begin
      reportCode = CODE_MODEM;
    end else begin
      reportValid = 1'b0;
    end
  end

  assign stickyAct = (flags[F_ABEND] && ienMask[EN_ABEND])
                  || (flags[F_ABTO] && ienMask[EN_ABTO])
                  || (flags[F_TXERR] && ienMask[EN_TXERR]);

  assign irq = reportValid || stickyAct;

  assign identWord = {21'b0, flags[F_TXERR], flags[F_ABTO], flags[F_ABEND],
                      {2{fifoEn}}, 2'b00, reportCode, ~reportValid};

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LVL_W             = 5,
  parameter int FRAME_W           = 4,
  parameter int TICKS_PER_BIT     = 16,
  parameter int FRAMES_PER_WINDOW = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoEn,
  input  logic [7:0]         ienMask,
  input  logic [3:0]         lineErr,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   rxTrigger,
  input  logic               rxPush,
  input  logic               baudTick,
  input  logic [FRAME_W-1:0] frameBits,
  input  logic               thrEmptyEvt,
  input  logic               txEmptyEvt,
  input  logic [3:0]         modemChg,
  input  logic               abEndEvt,
  input  logic               abToEvt,
  input  logic               txErrEvt,
  input  logic               abEndClr,
  input  logic               abToClr,
  input  logic               txErrClr,
  input  logic               rdIdent,
  input  logic               rdLineStat,
  input  logic               rdRxBuf,
  input  logic               rdModem,
  input  logic               wrThr,
  output logic [31:0]        identWord,
  output logic               irq
);

  irq_strobe_t strobe;
  irq_code_e   reportCode;
  logic        reportValid;

  uart_irq_ctrl u_ctrl (
    .rdIdent    (rdIdent),
    .rdLineStat (rdLineStat),
    .rdRxBuf    (rdRxBuf),
    .rdModem    (rdModem),
    .wrThr      (wrThr),
    .rxPush     (rxPush),
    .abEndClr   (abEndClr),
    .abToClr    (abToClr),
    .txErrClr   (txErrClr),
    .reportCode (reportCode),
    .reportValid(reportValid),
    .strobe     (strobe)
  );

  uart_irq_datapath #(
    .LVL_W            (LVL_W),
    .FRAME_W          (FRAME_W),
    .TICKS_PER_BIT    (TICKS_PER_BIT),
    .FRAMES_PER_WINDOW(FRAMES_PER_WINDOW)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .fifoEn     (fifoEn),
    .ienMask    (ienMask),
    .lineErr    (lineErr),
    .rxLevel    (rxLevel),
    .rxTrigger  (rxTrigger),
    .baudTick   (baudTick),
    .frameBits  (frameBits),
    .thrEmptyEvt(thrEmptyEvt),
    .txEmptyEvt (txEmptyEvt),
    .modemChg   (modemChg),
    .abEndEvt   (abEndEvt),
    .abToEvt    (abToEvt),
    .txErrEvt   (txErrEvt),
    .strobe     (strobe),
    .reportCode (reportCode),
    .reportValid(reportValid),
    .identWord  (identWord),
    .irq        (irq)
  );

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [7:0]       ienMask,
  input logic [3:0]       lineErr,
  input logic [LVL_W-1:0] rxLevel,
  input logic [LVL_W-1:0] rxTrigger,
  input logic             thrEmptyEvt,
  input logic [3:0]       modemChg,
  input logic             abEndEvt,
  input logic             abEndClr,
  input logic             rdLineStat,
  input logic             rdModem,
  input logic             wrThr,
  input logic [31:0]      identWord,
  input logic             irq
);

  // R2: nothing reported means code 0
  p_idle_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    identWord[0] |-> identWord[3:1] == 3'h0);

  // R12: a reported cause always raises the request
  p_pend_irq_r12: assert property (@(posedge clk) disable iff (!rstN)
    !identWord[0] |-> irq);

  // R4: a line-status read without a new error retires the line cause
  p_line_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdLineStat && lineErr == 4'h0) |=> identWord[3:1] != 3'h3);

  // R7: a holding-register write retires the holding-empty cause
  p_thre_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrThr && !thrEmptyEvt) |=> identWord[3:1] != 3'h1);

  // R8: a modem-status read without a new change retires the modem cause
  p_modem_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdModem && modemChg == 4'h0) |=> (identWord[0] || identWord[3:1] != 3'h0));

  // R3: data available outranks everything below line status
  p_rda_rank_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ienMask[1] && rxLevel != '0 && rxLevel >= rxTrigger && identWord[3:1] != 3'h3)
      |-> (identWord[3:1] == 3'h2 && !identWord[0]));

  // R9: auto-baud done bit holds until its clear strobe
  p_abend_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (identWord[8] && !abEndClr) |=> identWord[8]);

  // R9: auto-baud done bit only rises on an enabled event
  p_abend_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!identWord[8] && !(abEndEvt && ienMask[5])) |=> !identWord[8]);

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ienMask    (ienMask),
  .lineErr    (lineErr),
  .rxLevel    (rxLevel),
  .rxTrigger  (rxTrigger),
  .thrEmptyEvt(thrEmptyEvt),
  .modemChg   (modemChg),
  .abEndEvt   (abEndEvt),
  .abEndClr   (abEndClr),
  .rdLineStat (rdLineStat),
  .rdModem    (rdModem),
  .wrThr      (wrThr),
  .identWord  (identWord),
  .irq        (irq)
);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

  localparam int LVL_W   = 5;
  localparam int FRAME_W = 4;

  logic               clk = 1'b0;
  logic               rstN;
  logic               fifoEn;
  logic [7:0]         ienMask;
  logic [3:0]         lineErr;
  logic [LVL_W-1:0]   rxLevel;
  logic [LVL_W-1:0]   rxTrigger;
  logic               rxPush;
  logic               baudTick;
  logic [FRAME_W-1:0] frameBits;
  logic               thrEmptyEvt;
  logic               txEmptyEvt;
  logic [3:0]         modemChg;
  logic               abEndEvt;
  logic               abToEvt;
  logic               txErrEvt;
  logic               abEndClr;
  logic               abToClr;
  logic               txErrClr;
  logic               rdIdent;
  logic               rdLineStat;
  logic               rdRxBuf;
  logic               rdModem;
  logic               wrThr;
  logic [31:0]        identWord;
  logic               irq;

  int vecCount  = 0;
  int missCount = 0;

  always #4 clk = ~clk;

  uart_irq_ident #(.LVL_W(LVL_W), .FRAME_W(FRAME_W)) u_uart_irq_ident (.*);

  typedef struct packed {
    logic [3:0]  lineErr;
    logic [3:0]  modemChg;
    logic        thrE;
    logic        temtE;
    logic [4:0]  lvl;
    logic [4:0]  trig;
    logic        rdId;
    logic        rdLs;
    logic        rdMs;
    logic        wrT;
    logic [7:0]  ien;
    logic [10:0] expId;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VECS [NVEC] = '{
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd0, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0C1, 1'b0}, // R2 idle
    '{4'h0, 4'h0, 1'b1, 1'b0, 5'd0, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0C2, 1'b1}, // R2 holding empty
    '{4'h0, 4'h1, 1'b0, 1'b0, 5'd0, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0C2, 1'b1}, // R3 modem below holding
    '{4'h2, 4'h0, 1'b0, 1'b0, 5'd0, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0C6, 1'b1}, // R4 parity error on top
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd4, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0C6, 1'b1}, // R3 line over data
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd4, 5'd4, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 11'h0C4, 1'b1}, // R5 data at trigger
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0C2, 1'b1}, // R5 below trigger
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0C0, 1'b1}, // R7 ident read
    '{4'h0, 4'h0, 1'b0, 1'b1, 5'd3, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0CE, 1'b1}, // R2 tx empty
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd4, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 11'h0CE, 1'b1}, // R8 modem read
    '{4'h0, 4'h0, 1'b1, 1'b0, 5'd3, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0C2, 1'b1}, // R3 holding over tx empty
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0CE, 1'b1}, // R7 read keeps tx empty
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd4, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 11'h0C1, 1'b0}, // R7 write clears
    '{4'h8, 4'h0, 1'b1, 1'b0, 5'd3, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 11'h0C1, 1'b0}, // R12 all disabled
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 11'h0C6, 1'b1}, // R12 line revealed
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd4, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 11'h0C2, 1'b1}, // R4 read clears
    '{4'h4, 4'h0, 1'b0, 1'b0, 5'd3, 5'd4, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 11'h0C6, 1'b1}, // R4 framing error
    '{4'h1, 4'h0, 1'b0, 1'b0, 5'd3, 5'd4, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 11'h0C6, 1'b1}, // R4 set wins
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd4, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 11'h0C1, 1'b0}, // R4 cleared
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd5, 5'd5, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0C4, 1'b1}, // R5 level 5 trigger 5
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd0, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0C1, 1'b0}, // R5 empty
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd6, 5'd5, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFD, 11'h0C1, 1'b0}, // R12 data disabled
    '{4'h0, 4'h0, 1'b0, 1'b0, 5'd0, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 11'h0C1, 1'b0}  // R2 idle again
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    missCount++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    rstN = 1'b0; fifoEn = 1'b0; ienMask = 8'h00; lineErr = 4'h0;
    rxLevel = '0; rxTrigger = 5'd4; rxPush = 1'b0; baudTick = 1'b0;
    frameBits = 4'd5; thrEmptyEvt = 1'b0; txEmptyEvt = 1'b0; modemChg = 4'h0;
    abEndEvt = 1'b0; abToEvt = 1'b0; txErrEvt = 1'b0; abEndClr = 1'b0;
    abToClr = 1'b0; txErrClr = 1'b0; rdIdent = 1'b0; rdLineStat = 1'b0;
    rdRxBuf = 1'b0; rdModem = 1'b0; wrThr = 1'b0;

    tick(3);
    chk("R1 in reset", identWord, 32'h0000_0001);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    rstN = 1'b1;
    tick(1);
    chk("R1 after reset", identWord, 32'h0000_0001);
    fifoEn = 1'b1;
    tick(1);
    chk("R11 fifo bits", identWord, 32'h0000_00C1);

    // table walk: one cycle per vector, sampled on the next falling edge
    for (int v = 0; v < NVEC; v++) begin
      lineErr = VECS[v].lineErr; modemChg = VECS[v].modemChg;
      thrEmptyEvt = VECS[v].thrE; txEmptyEvt = VECS[v].temtE;
      rxLevel = VECS[v].lvl; rxTrigger = VECS[v].trig;
      rdIdent = VECS[v].rdId; rdLineStat = VECS[v].rdLs;
      rdModem = VECS[v].rdMs; wrThr = VECS[v].wrT; ienMask = VECS[v].ien;
      tick(1);
      chk($sformatf("R2/R3 table vector %0d ident", v), identWord, {21'b0, VECS[v].expId});
      chk($sformatf("R12 table vector %0d irq", v), {31'b0, irq}, {31'b0, VECS[v].expIrq});
    end
    lineErr = 4'h0; modemChg = 4'h0; thrEmptyEvt = 1'b0; txEmptyEvt = 1'b0;
    rdIdent = 1'b0; rdLineStat = 1'b0; rdModem = 1'b0; wrThr = 1'b0;
    ienMask = 8'hFF; rxTrigger = 5'd4;

    // R6: 5-bit frames give a 320-tick window
    rxLevel = 5'd2; rxPush = 1'b1; baudTick = 1'b1;
    tick(1);
    rxPush = 1'b0;
    tick(319);
    chk("R6 one tick before window", identWord, 32'h0000_00C1);
    tick(1);
    chk("R6 window complete", identWord, 32'h0000_00CC);
    chk("R6 irq", {31'b0, irq}, 32'h1);
    rdRxBuf = 1'b1; rxLevel = 5'd1;
    tick(1);
    rdRxBuf = 1'b0;
    chk("R6 buffer read clears", identWord, 32'h0000_00C1);
    tick(300);
    rxPush = 1'b1; rxLevel = 5'd2;
    tick(1);
    rxPush = 1'b0;
    tick(319);
    chk("R6 push restarted count", identWord, 32'h0000_00C1);
    tick(1);
    chk("R6 expires after restart", identWord, 32'h0000_00CC);
    rdRxBuf = 1'b1; rxLevel = 5'd0;
    tick(1);
    rdRxBuf = 1'b0; baudTick = 1'b0;
    chk("R6 empty clears", identWord, 32'h0000_00C1);

    // R9: auto-baud flags
    ienMask = 8'hDF; abEndEvt = 1'b1;
    tick(1);
    abEndEvt = 1'b0;
    chk("R9 disabled end event ignored", identWord, 32'h0000_00C1);
    ienMask = 8'hFF; abEndEvt = 1'b1;
    tick(1);
    abEndEvt = 1'b0;
    chk("R9 end flag set", identWord, 32'h0000_01C1);
    chk("R12 irq from end flag", {31'b0, irq}, 32'h1);
    rdIdent = 1'b1;
    tick(1);
    rdIdent = 1'b0;
    chk("R9 read keeps end flag", identWord, 32'h0000_01C1);
    abEndClr = 1'b1;
    tick(1);
    abEndClr = 1'b0;
    chk("R9 end flag cleared", identWord, 32'h0000_00C1);
    abToEvt = 1'b1;
    tick(1);
    abToEvt = 1'b0;
    chk("R9 timeout flag set", identWord, 32'h0000_02C1);
    abToClr = 1'b1;
    tick(1);
    abToClr = 1'b0;
    chk("R9 timeout flag cleared", identWord, 32'h0000_00C1);

    // R10: transmit error flag
    ienMask = 8'h7F; txErrEvt = 1'b1;
    tick(1);
    txErrEvt = 1'b0;
    chk("R10 disabled tx error ignored", identWord, 32'h0000_00C1);
    ienMask = 8'hFF; txErrEvt = 1'b1;
    tick(1);
    txErrEvt = 1'b0;
    chk("R10 tx error set", identWord, 32'h0000_04C1);
    chk("R12 irq from tx error", {31'b0, irq}, 32'h1);
    txErrClr = 1'b1;
    tick(1);
    txErrClr = 1'b0;
    chk("R10 tx error cleared", identWord, 32'h0000_00C1);
    chk("R12 irq idle", {31'b0, irq}, 32'h0);

    // R11: FIFO bits follow the input
    fifoEn = 1'b0;
    tick(1);
    chk("R11 fifo off", identWord, 32'h0000_0001);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule